// File: doc/BRIEF.md
# DS3 Payload Bit-Stuff Decision Controller

This block chooses, once per STS-1 synchronous payload envelope (SPE), how many DS3 data bits that SPE carries. A DS3 tributary is not locked to the SONET reference: it may run up to 20 ppm fast or slow against an STS-1 clock that is itself up to 20 ppm off. Each SPE has nine single-bit stuff opportunities. Nominally three of them carry data, which gives 5592 data bits. The controller moves that number up or down by one bit per SPE, so the tributary crosses the mapping without losing or repeating bits.

The mapper's elastic buffer reports its fill level as a signed word count, together with a strobe at the start of each SPE. At every strobe the controller compares the fill against an upper and a lower threshold, with hysteresis, and picks one of three settings:
- 4 data opportunities (5593 bits, negative stuff);
- 3 data opportunities (5592 bits, nominal);
- 2 data opportunities (5591 bits, positive stuff).

For each stuff opportunity that the mapper presents, a select line tells it whether to put data or stuff in that opportunity. Two saturating counters record negative-stuff and positive-stuff events, and a synchronous clear input resets them.

Top module: `ds3_spe_stuff_ctrl`

## Requirements
- R1: After reset, data_opps is 3, data_bits is 5592, and both event counters are 0.
- R2: When a strobe samples fill_level above HI_TH (default 4), then from the next cycle data_opps is 4 and data_bits is 5593, whatever the previous setting was.
- R3: When a strobe samples fill_level below LO_TH (default -4), then from the next cycle data_opps is 2 and data_bits is 5591, whatever the previous setting was.
- R4: In the nominal setting, a strobe with LO_TH <= fill_level <= HI_TH leaves data_opps at 3 and data_bits at 5592. The threshold values themselves (4 and -4) count as inside this range.
- R5: Hysteresis applies to both stuffing settings:
  - The 4-opportunity setting is kept at a strobe while fill_level > HI_TH-HYST (default 2). It falls back to 3 once fill_level is at or below that value and not below LO_TH.
  - The 2-opportunity setting is kept while fill_level < LO_TH+HYST (default -2). It falls back to 3 once fill_level is at or above that value and not above HI_TH.
- R6: In a cycle without a strobe, the setting and the counters do not change, whatever fill_level is.
- R7: opp_is_data is 1 exactly when opp_idx < data_opps. Data fills opportunities in order from opportunity 0. Any opp_idx of NUM_OPPS (9) or more gives 0.
- R8: Each strobe that selects 4 opportunities adds one to neg_stuff_cnt. Each strobe that selects 2 adds one to pos_stuff_cnt. Both counters stop at 2^CNT_W-1.
- R9: cnt_clr sets both counters to 0 in the next cycle. It wins over an event that is counted in the same cycle, but it does not stop the setting change of that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spe_start | input | 1 | One-cycle strobe at the start of each SPE |
| fill_level | input | FILL_W | Signed elastic-buffer fill, in words, relative to the centre |
| opp_idx | input | OPP_W | Index of the stuff opportunity currently being emitted |
| cnt_clr | input | 1 | Synchronous clear of both event counters |
| data_opps | output | OPP_W | Number of stuff opportunities that carry data in this SPE |
| data_bits | output | BITS_W | DS3 data bits carried by this SPE |
| opp_is_data | output | 1 | 1 = the opportunity at opp_idx carries data, 0 = stuff |
| neg_stuff_cnt | output | CNT_W | Saturating count of negative-stuff SPEs |
| pos_stuff_cnt | output | CNT_W | Saturating count of positive-stuff SPEs |

## Verification
The counter clear and the event count can fall in the same cycle. The bench provokes this by asserting cnt_clr in the same cycle as a strobe whose fill level forces a negative stuff. It then expects, in the following cycle, both counters at zero while data_opps has still moved to 4. The bench also drives counters into saturation with a small CNT_W, and it walks the fill level across each threshold and each hysteresis edge from both directions.

// File: rtl/stuff_pkg.sv
package stuff_pkg;
   typedef enum logic [1:0] {
      MODE_NOM  = 2'd0,
      MODE_FAST = 2'd1,
      MODE_SLOW = 2'd2
   } stuff_mode_e;
endpackage

// File: rtl/stuff_decide.sv
module stuff_decide
   import stuff_pkg::*;
#(
   parameter int FILL_W = 8,
   parameter int HI_TH  = 4,
   parameter int LO_TH  = -4,
   parameter int HYST   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spe_start,
   input  logic signed [FILL_W-1:0] fill_level,
   output stuff_mode_e              mode_q,
   output logic                     neg_evt,
   output logic                     pos_evt
);
   localparam int FAST_KEEP = HI_TH - HYST;
   localparam int SLOW_KEEP = LO_TH + HYST;

   stuff_mode_e mode_d;
   logic        above_hi, below_lo, keep_fast, keep_slow;

   always_comb begin
      above_hi  = (int'(fill_level) > HI_TH);
      below_lo  = (int'(fill_level) < LO_TH);
      keep_fast = (int'(fill_level) > FAST_KEEP);
      keep_slow = (int'(fill_level) < SLOW_KEEP);
      mode_d    = MODE_NOM;
      unique case (mode_q)
         MODE_FAST: mode_d = keep_fast ? MODE_FAST : (below_lo ? MODE_SLOW : MODE_NOM);
         MODE_SLOW: mode_d = keep_slow ? MODE_SLOW : (above_hi ? MODE_FAST : MODE_NOM);
         default:   mode_d = above_hi ? MODE_FAST : (below_lo ? MODE_SLOW : MODE_NOM);
      endcase
   end

   assign neg_evt = spe_start && (mode_d == MODE_FAST);
   assign pos_evt = spe_start && (mode_d == MODE_SLOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mode_q <= MODE_NOM;
      else if (spe_start) mode_q <= mode_d;
   end

   // R6: the setting only moves on a strobe
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !spe_start |=> $stable(mode_q));
   // R2 / R3: threshold crossings override any previous setting
   p_enter_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (spe_start && int'(fill_level) > HI_TH) |=> (mode_q == MODE_FAST));
   p_enter_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (spe_start && int'(fill_level) < LO_TH) |=> (mode_q == MODE_SLOW));
endmodule

// File: rtl/stuff_sat_cnt.sv
module stuff_sat_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (clr)                    cnt <= '0;
      else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
   end

   // R8: a full counter stays full until cleared
   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
   // R9: clear wins over a coincident increment
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/stuff_opp_map.sv
module stuff_opp_map
   import stuff_pkg::*;
#(
   parameter int NUM_OPPS      = 9,
   parameter int NOM_DATA_OPPS = 3,
   parameter int NOM_DATA_BITS = 5592,
   parameter int OPP_W         = 4,
   parameter int BITS_W        = 13
) (
   input  stuff_mode_e       mode,
   input  logic [OPP_W-1:0]  opp_idx,
   output logic [OPP_W-1:0]  data_opps,
   output logic [BITS_W-1:0] data_bits,
   output logic              opp_is_data
);
   localparam logic [OPP_W-1:0]  OPPS_NOM  = OPP_W'(NOM_DATA_OPPS);
   localparam logic [OPP_W-1:0]  OPPS_LAST = OPP_W'(NUM_OPPS);
   localparam logic [BITS_W-1:0] BITS_BASE = BITS_W'(NOM_DATA_BITS - NOM_DATA_OPPS);

   always_comb begin
      unique case (mode)
         MODE_FAST: data_opps = OPPS_NOM + 1'b1;
         MODE_SLOW: data_opps = OPPS_NOM - 1'b1;
         default:   data_opps = OPPS_NOM;
      endcase
   end

   assign data_bits   = BITS_BASE + BITS_W'(data_opps);
   assign opp_is_data = (opp_idx < OPPS_LAST) && (opp_idx < data_opps);
endmodule

// File: rtl/ds3_spe_stuff_ctrl.sv
module ds3_spe_stuff_ctrl
   import stuff_pkg::*;
#(
   parameter int FILL_W        = 8,
   parameter int HI_TH         = 4,
   parameter int LO_TH         = -4,
   parameter int HYST          = 2,
   parameter int NUM_OPPS      = 9,
   parameter int NOM_DATA_OPPS = 3,
   parameter int NOM_DATA_BITS = 5592,
   parameter int CNT_W         = 8,
   parameter int OPP_W         = $clog2(NUM_OPPS + 1),
   parameter int BITS_W        = $clog2(NOM_DATA_BITS + 2)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spe_start,
   input  logic signed [FILL_W-1:0] fill_level,
   input  logic [OPP_W-1:0]         opp_idx,
   input  logic                     cnt_clr,
   output logic [OPP_W-1:0]         data_opps,
   output logic [BITS_W-1:0]        data_bits,
   output logic                     opp_is_data,
   output logic [CNT_W-1:0]         neg_stuff_cnt,
   output logic [CNT_W-1:0]         pos_stuff_cnt
);
   localparam int NUM_CNT = 2;

   if (HI_TH - LO_TH <= 2 * HYST) begin : g_bad_hyst
      $error("hysteresis bands overlap");
   end
   if (NOM_DATA_OPPS < 1 || NOM_DATA_OPPS > NUM_OPPS - 1) begin : g_bad_opps
      $error("nominal data opportunities leave no room to stuff");
   end
   if (HYST < 0 || CNT_W < 1) begin : g_bad_misc
      $error("illegal HYST or CNT_W");
   end

   stuff_mode_e              mode_q;
   logic [NUM_CNT-1:0]       evt;
   logic [CNT_W-1:0]         cnt_arr [NUM_CNT];

   stuff_decide #(
      .FILL_W(FILL_W), .HI_TH(HI_TH), .LO_TH(LO_TH), .HYST(HYST)
   ) u_decide (
      .clk(clk), .rst_n(rst_n), .spe_start(spe_start), .fill_level(fill_level),
      .mode_q(mode_q), .neg_evt(evt[0]), .pos_evt(evt[1])
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      stuff_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(evt[i]), .cnt(cnt_arr[i])
      );
   end

   assign neg_stuff_cnt = cnt_arr[0];
   assign pos_stuff_cnt = cnt_arr[1];

   stuff_opp_map #(
      .NUM_OPPS(NUM_OPPS), .NOM_DATA_OPPS(NOM_DATA_OPPS), .NOM_DATA_BITS(NOM_DATA_BITS),
      .OPP_W(OPP_W), .BITS_W(BITS_W)
   ) u_map (
      .mode(mode_q), .opp_idx(opp_idx), .data_opps(data_opps),
      .data_bits(data_bits), .opp_is_data(opp_is_data)
   );

   // R8: a negative-stuff count advances only after a strobe
   p_neg_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!spe_start && !cnt_clr) |=> $stable(neg_stuff_cnt) && $stable(pos_stuff_cnt));
   // R7: never more data opportunities selected than the SPE has
   p_sel_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      opp_is_data |-> (opp_idx < OPP_W'(NUM_OPPS)));
endmodule

// File: tb/ds3_spe_stuff_ctrl_tb.sv
module ds3_spe_stuff_ctrl_tb;
   localparam int FILL_W = 8;
   localparam int CNT_W  = 4;
   localparam int OPP_W  = 4;
   localparam int BITS_W = 13;
   localparam int HI = 4, LO = -4, HY = 2;
   localparam int CMAX = (1 << CNT_W) - 1;

   typedef struct { int opps; int bits; int neg; int pos; string req; } exp_t;

   logic clk = 0, rst_n = 0, spe_start = 0, cnt_clr = 0;
   logic signed [FILL_W-1:0] fill_level = '0;
   logic [OPP_W-1:0] opp_idx = '0;
   logic [OPP_W-1:0] data_opps;
   logic [BITS_W-1:0] data_bits;
   logic opp_is_data;
   logic [CNT_W-1:0] neg_stuff_cnt, pos_stuff_cnt;

   int n_chk = 0, n_fail = 0;
   int m_opps = 3, m_neg = 0, m_pos = 0;
   exp_t q[$];
   bit done = 0;

   always #2 clk = ~clk;

   ds3_spe_stuff_ctrl #(.FILL_W(FILL_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .spe_start(spe_start), .fill_level(fill_level),
      .opp_idx(opp_idx), .cnt_clr(cnt_clr), .data_opps(data_opps), .data_bits(data_bits),
      .opp_is_data(opp_is_data), .neg_stuff_cnt(neg_stuff_cnt), .pos_stuff_cnt(pos_stuff_cnt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // driver: one cycle of stimulus, then push the modelled result
   task automatic step(input bit strb, input int fill, input bit clr, input string req);
      exp_t e;
      @(negedge clk);
      spe_start = strb; fill_level = FILL_W'(fill); cnt_clr = clr;
      @(posedge clk);
      if (strb) begin
         if (m_opps == 4)      m_opps = (fill > HI - HY) ? 4 : (fill < LO ? 2 : 3);
         else if (m_opps == 2) m_opps = (fill < LO + HY) ? 2 : (fill > HI ? 4 : 3);
         else                  m_opps = (fill > HI) ? 4 : (fill < LO ? 2 : 3);
      end
      if (clr) begin m_neg = 0; m_pos = 0; end
      else if (strb) begin
         if (m_opps == 4 && m_neg < CMAX) m_neg++;
         if (m_opps == 2 && m_pos < CMAX) m_pos++;
      end
      e.opps = m_opps; e.bits = 5589 + m_opps; e.neg = m_neg; e.pos = m_pos; e.req = req;
      q.push_back(e);
      #0 spe_start = spe_start;
   endtask

   task automatic sweep_opps(input string req);
      @(negedge clk);
      spe_start = 0; cnt_clr = 0;
      for (int i = 0; i < 12; i++) begin
         opp_idx = OPP_W'(i);
         #0.5;
         chk(req, $sformatf("opp_is_data[%0d]", i), int'(opp_is_data), (i < 9 && i < m_opps) ? 1 : 0);
      end
      opp_idx = '0;
   endtask

   // monitor: pops expectations and compares on the falling edge
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            e = q.pop_front();
            chk(e.req, "data_opps", int'(data_opps), e.opps);
            chk(e.req, "data_bits", int'(data_bits), e.bits);
            chk(e.req, "neg_stuff_cnt", int'(neg_stuff_cnt), e.neg);
            chk(e.req, "pos_stuff_cnt", int'(pos_stuff_cnt), e.pos);
         end
      end
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "data_opps", int'(data_opps), 3);
      chk("R1", "data_bits", int'(data_bits), 5592);
      chk("R1", "neg_stuff_cnt", int'(neg_stuff_cnt), 0);
      chk("R1", "pos_stuff_cnt", int'(pos_stuff_cnt), 0);
      rst_n = 1;
      step(1, 0, 0, "R4");
      step(1, 4, 0, "R4");          // exactly at upper threshold
      step(1, -4, 0, "R4");         // exactly at lower threshold
      step(1, 5, 0, "R2");
      sweep_opps("R7");
      step(1, 3, 0, "R5");          // stays fast
      step(1, 2, 0, "R5");          // falls back
      step(0, 100, 0, "R6");
      step(0, -100, 0, "R6");
      step(1, -5, 0, "R3");
      sweep_opps("R7");
      step(1, -3, 0, "R5");         // stays slow
      step(1, -2, 0, "R5");         // falls back
      step(1, -128, 0, "R3");
      step(1, 127, 0, "R2");        // slow straight to fast
      step(0, -128, 0, "R6");
      step(1, -100, 0, "R3");       // fast straight to slow
      sweep_opps("R7");
      step(1, 0, 0, "R4");
      sweep_opps("R7");
      step(0, 0, 1, "R9");
      step(1, 50, 1, "R9");         // clear coincides with negative stuff
      for (int i = 0; i < CMAX + 3; i++) step(1, 20, 0, "R8");
      for (int i = 0; i < CMAX + 3; i++) step(1, -20, 0, "R8");
      step(0, 0, 0, "R8");
      step(1, -20, 1, "R9");
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule